// File: doc/BRIEF.md
# IR carrier modulating symbol transmitter

This block turns a stream of 32-bit symbol words, pulled from a transmit queue over a valid/ready port, into an infrared drive waveform on one pin. A divider of the system clock makes a carrier whose period and high time are both programmable. A mark symbol lets that carrier through for a counted number of carrier periods. A space symbol holds the pin at its inactive level. A space can instead be timed in units of a second, finer compensation clock. This lets a gap that is not a whole number of carrier periods be matched closely.

A transfer begins on a rising edge of the start request. From then on, words are taken back to back. A new word is taken only in the cycle in which the current symbol ends, so no idle cycles appear between symbols. A word that carries the end flag closes the transfer. If the queue is empty at a symbol boundary and no end flag has been seen, the transfer stops and an underrun flag is raised.

Top module: `ir_sym_tx`

## Requirements
- R1: The carrier period is div_i+1 system clocks. A mark symbol with time count t lasts exactly (t+1)*(div_i+1) clocks. Its carrier phase restarts at count 0 in the first clock of every mark symbol.
- R2: Within each carrier period, the carrier is high for the first duty_i clocks and low for the rest. When duty_i >= div_i the carrier is high for the whole period (100% duty).
- R3: Word format: bit 31 is the level (1 = mark, 0 = space), bit 30 is the end flag, bits 29:28 are the timing mode, and bits 27:0 are the time count t.
- R4: A space symbol with mode 3 lasts (t+1)*(comp_div_i+1) clocks. A space with mode 0, 1 or 2 lasts (t+1)*(div_i+1) clocks. A space drives the inactive (un-inverted 0) level throughout.
- R5: A mark symbol always counts carrier periods, even when its mode field is 3.
- R6: When the symbol of a word with the end flag finishes, busy_o drops and ir_o returns to idle_lvl_i in the next cycle. No further word is taken.
- R7: While a transfer runs, ir_o is the modulated waveform XOR out_inv_i. While no symbol is playing, ir_o equals idle_lvl_i and is not inverted.
- R8: A rising edge of start_i while idle raises busy_o on the next clock and takes the first word on the clock after that; ir_o stays at idle_lvl_i until that word plays. A rising edge of start_i while busy has no effect on the waveform.
- R9: If no word is valid when one is due (at a symbol boundary without end flag, or right after start), the block goes idle and sets underrun_o. underrun_o is cleared by the next accepted start edge.
- R10: During and after reset: busy_o=0, word_ready_o=0, underrun_o=0, and ir_o=idle_lvl_i.
- R11: Consecutive words play with no gap cycles, and word_ready_o is asserted only when a word is due.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, acted on at its rising edge |
| div_i | input | DIV_W | Carrier divider; period = div_i+1 clocks |
| duty_i | input | DIV_W | Carrier high time in clocks |
| comp_div_i | input | DIV_W | Compensation divider; unit = comp_div_i+1 clocks |
| out_inv_i | input | 1 | Invert the waveform while running |
| idle_lvl_i | input | 1 | Pin level while not running |
| word_i | input | 32 | Symbol word from the queue |
| word_valid_i | input | 1 | Queue holds a word |
| word_ready_o | output | 1 | Word taken this cycle if valid |
| ir_o | output | 1 | IR drive output |
| busy_o | output | 1 | Transfer in progress |
| underrun_o | output | 1 | Queue ran dry before an end flag |

## Verification
The end of one symbol and the loading of the next word fall in the same cycle. That same cycle also clears the carrier and compensation phase. The bench feeds back-to-back words of mixed level and mode, then compares the whole pin waveform, clock by clock, against a trace built from the length and duty rules. Any lost or extra cycle at a boundary shows up as a shifted trace. A start edge raised in the middle of a transfer also coincides with running symbols. It is judged by the waveform staying identical, and by the number of words taken from the queue.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;
  localparam int WORD_W = 32;
  localparam int TIME_W = 28;
  localparam logic [1:0] MODE_COMP = 2'd3;

  typedef struct packed {
    logic              mark;
    logic              last;
    logic [1:0]        mode;
    logic [TIME_W-1:0] dur;
  } tx_word_t;

  typedef enum logic [1:0] {ST_IDLE, ST_ARM, ST_RUN} seq_st_e;
endpackage

// File: rtl/ir_div_cnt.sv
module ir_div_cnt #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] lim_i,
  output logic [W-1:0] cnt_o,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q >= lim_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end

  // R1: counter advances by one per enabled clock until wrap
  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && !tick_o) |=> (cnt_o == $past(cnt_o) + 1'b1));
  // R1: phase restart on clear
  a_r1_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));
endmodule

// File: rtl/ir_sym_seq.sv
module ir_sym_seq
  import ir_tx_pkg::*;
#(
  parameter int TW = TIME_W
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     start_i,
  input  tx_word_t word_i,
  input  logic     word_valid_i,
  input  logic     carr_tick_i,
  input  logic     comp_tick_i,
  output logic     word_ready_o,
  output logic     load_o,
  output logic     run_o,
  output logic     mark_o,
  output logic     busy_o,
  output logic     underrun_o
);
  localparam logic [TW-1:0] ONE = 1;

  seq_st_e       st_q, st_d;
  logic          start_q, start_rise;
  logic          mark_q, last_q, comp_q;
  logic [TW-1:0] rem_q;
  logic          unit_tick, sym_done, starve, under_q;

  assign start_rise   = start_i && !start_q;
  assign unit_tick    = comp_q ? comp_tick_i : carr_tick_i;
  assign sym_done     = (st_q == ST_RUN) && unit_tick && (rem_q == '0);
  assign word_ready_o = (st_q == ST_ARM) || (sym_done && !last_q);
  assign load_o       = word_ready_o && word_valid_i;
  assign starve       = word_ready_o && !word_valid_i;
  assign run_o        = (st_q == ST_RUN);
  assign mark_o       = mark_q;
  assign busy_o       = (st_q != ST_IDLE);
  assign underrun_o   = under_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start_rise) st_d = ST_ARM;
      ST_ARM, ST_RUN: begin
        if (load_o)                 st_d = ST_RUN;
        else if (starve)            st_d = ST_IDLE;
        else if (sym_done && last_q) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      start_q <= 1'b0;
      mark_q  <= 1'b0;
      last_q  <= 1'b0;
      comp_q  <= 1'b0;
      rem_q   <= '0;
      under_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      start_q <= start_i;
      if (load_o) begin
        mark_q <= word_i.mark;
        last_q <= word_i.last;
        // compensation timing only for spaces
        comp_q <= !word_i.mark && (word_i.mode == MODE_COMP);
        rem_q  <= word_i.dur;
      end else if (run_o && unit_tick && rem_q != '0) begin
        rem_q <= rem_q - ONE;
      end
      if (st_q == ST_IDLE && start_rise) under_q <= 1'b0;
      else if (starve)                   under_q <= 1'b1;
    end
  end

  a_r3_load_dur: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (rem_q == $past(word_i.dur)));
  a_r6_end_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_done && last_q) |=> (!busy_o && !word_ready_o));
  a_r8_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_rise) |=> busy_o);
  a_r9_underrun_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(underrun_o) |-> !busy_o);
  a_r11_ready_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_ready_o |-> busy_o);
endmodule

// File: rtl/ir_sym_tx.sv
module ir_sym_tx
  import ir_tx_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic [DIV_W-1:0]  duty_i,
  input  logic [DIV_W-1:0]  comp_div_i,
  input  logic              out_inv_i,
  input  logic              idle_lvl_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              word_valid_i,
  output logic              word_ready_o,
  output logic              ir_o,
  output logic              busy_o,
  output logic              underrun_o
);
  localparam int N_DIV = 2;  // 0: carrier, 1: compensation

  tx_word_t         word;
  logic             load, run, mark, carr_hi;
  logic [DIV_W-1:0] lim   [N_DIV];
  logic [DIV_W-1:0] cnt   [N_DIV];
  logic [N_DIV-1:0] tick;

  assign word   = tx_word_t'(word_i);
  assign lim[0] = div_i;
  assign lim[1] = comp_div_i;

  for (genvar g = 0; g < N_DIV; g++) begin : g_div
    ir_div_cnt #(.W(DIV_W)) u_div (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (load),
      .en_i  (run),
      .lim_i (lim[g]),
      .cnt_o (cnt[g]),
      .tick_o(tick[g])
    );
  end

  ir_sym_seq #(.TW(TIME_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .word_i      (word),
    .word_valid_i(word_valid_i),
    .carr_tick_i (tick[0]),
    .comp_tick_i (tick[1]),
    .word_ready_o(word_ready_o),
    .load_o      (load),
    .run_o       (run),
    .mark_o      (mark),
    .busy_o      (busy_o),
    .underrun_o  (underrun_o)
  );

  assign carr_hi = (cnt[0] < duty_i) || (duty_i >= div_i);
  assign ir_o    = run ? ((mark && carr_hi) ^ out_inv_i) : idle_lvl_i;

  a_r7_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ir_o == idle_lvl_i));
  a_r2_full_duty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && mark && duty_i >= div_i) |-> (ir_o == !out_inv_i));
  a_r4_space_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !mark) |-> (ir_o == out_inv_i));
endmodule

// File: tb/tb_ir_sym_tx.sv
module tb_ir_sym_tx;
  localparam int DW = 12;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          start = 1'b0, inv = 1'b0, idle = 1'b0;
  logic [DW-1:0] div = 4, duty = 2, cdiv = 1;
  logic [31:0]   word;
  logic          wvalid, wready, ir, busy, under;

  logic [31:0] words [0:15];
  int          n_words = 0;
  int          ptr = 0;
  logic        fifo_rst = 1'b0;
  bit          exp_w [0:8191];
  int          exp_len, exp_used;
  int          n_chk = 0, n_bad = 0, cyc = 0;

  always #5 clk = ~clk;

  assign wvalid = (ptr < n_words);
  assign word   = words[ptr[3:0]];

  always @(posedge clk) begin
    if (fifo_rst) ptr <= 0;
    else if (wready && wvalid) ptr <= ptr + 1;
  end

  ir_sym_tx #(.DIV_W(DW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .div_i(div), .duty_i(duty),
    .comp_div_i(cdiv), .out_inv_i(inv), .idle_lvl_i(idle), .word_i(word),
    .word_valid_i(wvalid), .word_ready_o(wready), .ir_o(ir), .busy_o(busy),
    .underrun_o(under)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic [31:0] mk(bit mark, bit last, int mode, int t);
    return {mark, last, mode[1:0], t[27:0]};
  endfunction

  // expected trace from R1..R5, R7
  task automatic build_exp(output bit ends);
    exp_len = 0; exp_used = 0; ends = 0;
    for (int i = 0; i < n_words; i++) begin
      logic [31:0] w = words[i];
      int per = (!w[31] && w[29:28] == 2'd3) ? int'(cdiv) + 1 : int'(div) + 1;
      exp_used++;
      for (int u = 0; u <= int'(w[27:0]); u++)
        for (int p = 0; p < per; p++) begin
          bit v = w[31] && ((p < int'(duty)) || (duty >= div));
          exp_w[exp_len] = v ^ inv;
          exp_len++;
        end
      if (w[30]) begin ends = 1; break; end
    end
  endtask

  task automatic run_case(input string nm, input bit toggle);
    bit ends; int bad = 0, first = -1;
    @(negedge clk);
    start = 1'b0; fifo_rst = 1'b1;
    @(negedge clk);
    fifo_rst = 1'b0;
    build_exp(ends);
    chk(!busy && ir == idle, "R7 idle before start", ir, idle);
    start = 1'b1;
    @(negedge clk);
    chk(busy && ir == idle && !under, "R8/R9 armed, idle pin, underrun cleared",
        {busy, ir, under}, {1'b1, idle, 1'b0});
    for (int i = 0; i < exp_len; i++) begin
      @(negedge clk);
      if (ir !== exp_w[i]) begin bad++; if (first < 0) first = i; end
      if (toggle && i == 1) start = 1'b0;
      if (toggle && i == 3) start = 1'b1;
    end
    chk(bad == 0, {"R1/R2/R4/R5/R11 waveform ", nm}, first, -1);
    @(negedge clk);
    chk(!busy && ir == idle, {"R6/R9 idle after ", nm}, {busy, ir}, {1'b0, idle});
    chk(under == !ends, {"R9 underrun flag ", nm}, under, !ends);
    chk(ptr == exp_used, {"R6/R8/R11 words taken ", nm}, ptr, exp_used);
    start = 1'b0;
  endtask

  task automatic cfg(input int d, input int dt, input int cd, input bit iv, input bit il);
    @(negedge clk);
    div = d[DW-1:0]; duty = dt[DW-1:0]; cdiv = cd[DW-1:0]; inv = iv; idle = il;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed = 32'h1234;
    void'($urandom(seed));
    #1;
    chk(!busy && !wready && !under && ir == idle, "R10 reset state",
        {busy, wready, under, ir}, {3'b0, idle});
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !wready && !under, "R10 after reset", {busy, wready, under}, 0);

    // R3/R4 mixed, mode 3 space uses compensation clock
    cfg(5, 2, 2, 0, 0);
    words[0] = mk(1, 0, 0, 2); words[1] = mk(0, 0, 0, 1);
    words[2] = mk(1, 0, 0, 0); words[3] = mk(0, 1, 3, 3);
    words[4] = mk(1, 0, 0, 5);  // after end flag: must not be taken (R6)
    n_words = 5;
    run_case("basic", 0);

    // R2 full duty, duty == div and duty > div
    cfg(4, 4, 1, 0, 0);
    words[0] = mk(1, 0, 0, 2); words[1] = mk(0, 1, 0, 0); n_words = 2;
    run_case("duty=div", 0);
    cfg(3, 7, 1, 0, 0);
    run_case("duty>div", 0);

    // R5 mark with mode 3; R4 spaces in modes 1 and 2
    cfg(3, 1, 9, 0, 0);
    words[0] = mk(1, 0, 3, 2); words[1] = mk(0, 0, 1, 1);
    words[2] = mk(0, 0, 2, 1); words[3] = mk(0, 1, 3, 0); n_words = 4;
    run_case("modes", 0);

    // R7 invert with idle level 1
    cfg(4, 2, 3, 1, 1);
    words[0] = mk(1, 0, 0, 1); words[1] = mk(0, 0, 3, 2); words[2] = mk(1, 1, 0, 0);
    n_words = 3;
    run_case("invert", 0);

    // R1 boundary div = 0
    cfg(0, 0, 0, 0, 0);
    words[0] = mk(1, 0, 0, 3); words[1] = mk(0, 0, 0, 2); words[2] = mk(1, 1, 0, 1);
    n_words = 3;
    run_case("div0", 0);

    // R9 underrun: no end flag
    cfg(3, 1, 2, 0, 1);
    words[0] = mk(1, 0, 0, 1); words[1] = mk(0, 0, 3, 1); n_words = 2;
    run_case("underrun", 0);
    // R9 empty queue at start
    n_words = 0;
    run_case("empty", 0);

    // R8 start edge while busy is ignored
    cfg(4, 2, 2, 0, 0);
    words[0] = mk(1, 0, 0, 3); words[1] = mk(0, 0, 0, 2); words[2] = mk(1, 1, 0, 1);
    n_words = 3;
    run_case("restart-busy", 1);

    // random cases
    for (int k = 0; k < 8; k++) begin
      int n = 1 + int'($urandom_range(4, 0));
      cfg(1 + int'($urandom_range(8, 0)), int'($urandom_range(10, 0)),
          int'($urandom_range(12, 0)), 1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)));
      for (int i = 0; i < n; i++)
        words[i] = mk(1'($urandom_range(1, 0)), i == n - 1 && k != 5, int'($urandom_range(3, 0)),
                      int'($urandom_range(5, 0)));
      n_words = n;
      run_case($sformatf("rand%0d", k), k[0]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule